// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital switching control of a single-phase hysteretic buck converter. There is no error amplifier and no fixed-frequency modulator. A flag from an external core comparator says whether the feedback voltage sits below the reference. While it does, the block requests the high-side switch; otherwise it requests the low-side switch. All timing is counted in cycles of a fast system clock.

Around that basic decision the sequencer enforces several rules. A break-before-make gap of programmable length separates the two gate enables. A zero-crossing latch turns the low side off when inductor current reaches zero, which gives diode-emulation power save at light load. A hysteretic current-limit gate removes the high side when current exceeds the upper limit and releases it only once current has fallen below the lower limit. Each high-side turn-on starts in a weak-drive phase before full drive.

Two inputs from fault logic act on the sequence. A driver-disable input turns both switches off. A force-low input holds the low side on with the high side off. A one-cycle tick marks every high-side turn-on so that downstream logic can count switching cycles.

Top module: `buck_gate_seq`

## Requirements
- R1: `hs_on` and `ls_on` are never high in the same cycle.
- R2: With no limit, fault or disable active, `hs_on` may be high only after an edge where `fb_below` was 1. `ls_on` may be high only after an edge where `fb_below` was 0. Each turn-on follows at least DEAD_CYC consecutive cycles with the opposite output low. From reset, the first turn-on is seen DEAD_CYC cycles after reset is released. A change of request while the other side is on turns the new side on DEAD_CYC+1 cycles after the change.
- R3: A `zc_det` pulse seen while the high side is not wanted latches the low side off. The latch holds with `zc_det` low. It clears when the high side is next wanted, after which the low side may turn on again.
- R4: `ilim_over` high at an edge forces `hs_on` low after that edge. `hs_on` stays low until an edge where `ilim_under` is 1 and `ilim_over` is 0.
- R5: Every high-side on-period begins with `hs_weak` high for exactly WEAK_CYC cycles, or for the whole period if it is shorter. `hs_weak` is low at all other times.
- R6: `sw_tick` is high for exactly the first cycle of each `hs_on` period and low otherwise.
- R7: `drv_off` high at an edge makes both `hs_on` and `ls_on` low after that edge. It takes precedence over `fault_low`.
- R8: `fault_low` high at an edge, with `drv_off` low, forces `hs_on` low after that edge. The low side then turns on regardless of `fb_below` and of the zero-crossing latch.
- R9: Under `fault_low`, if the last output on was the low side, the low side turns on at the next edge without waiting for the gap. If the last output on was the high side, the full DEAD_CYC gap is kept.
- R10: While `rst_n` is low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_below | input | 1 | Core comparator: 1 when feedback is below reference |
| zc_det | input | 1 | Zero-crossing flag: inductor current has reached zero |
| ilim_over | input | 1 | Current above the upper limit |
| ilim_under | input | 1 | Current below the lower limit |
| drv_off | input | 1 | Disable / lockout: both switches off |
| fault_low | input | 1 | Fault hold: low side on, high side off |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| hs_weak | output | 1 | High-side weak-drive select (1 = weak) |
| sw_tick | output | 1 | One-cycle pulse on each high-side turn-on |

## Verification
The assertions take all flags as already synchronous to `clk`. They also assume that a flag's value at an edge is the value that counts, with no meaning given to its width. The bench drives every input one time unit after the falling edge, so each flag is stable across the rising edge it is meant for. The bench then reads the outputs at the next falling edge. The random phase holds `fb_below` for several cycles at a time and raises the fault, disable and current-limit flags only rarely. This keeps most of the run inside ordinary switching, where the dead-time, power-save and weak-drive rules can be observed.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/bgs_ilim_gate.sv
module bgs_ilim_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ilim_over,
  input  logic ilim_under,
  output logic hs_allow
);
  logic blk_q, blk_d;

  always_comb begin
    blk_d = blk_q;
    if (ilim_over)       blk_d = 1'b1;
    else if (ilim_under) blk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= blk_d;
  end

  assign hs_allow = !blk_q && !ilim_over;

  AST_ILIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_allow && !ilim_under) |=> !hs_allow); // R4
endmodule

// File: rtl/bgs_zc_latch.sv
module bgs_zc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_det,
  input  logic want_high,
  output logic ls_block
);
  logic zc_q, zc_d;

  always_comb begin
    zc_d = zc_q;
    if (want_high)   zc_d = 1'b0;
    else if (zc_det) zc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_q <= 1'b0;
    else        zc_q <= zc_d;
  end

  assign ls_block = zc_q || (zc_det && !want_high);

  AST_ZC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_block && !want_high) |=> (ls_block || want_high)); // R3
endmodule

// File: rtl/bgs_phase_fsm.sv
module bgs_phase_fsm
  import bgs_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic ls_req,
  input  logic force_low,
  output logic hs_on,
  output logic ls_on
);
  localparam int GW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(DEAD_CYC - 1);

  phase_e        ph_q, ph_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          hs_rec_q, hs_rec_d;
  logic          gap_done;

  assign gap_done = (gap_q == GAP_LAST);

  always_comb begin
    ph_d     = ph_q;
    gap_d    = gap_q;
    hs_rec_d = hs_rec_q;
    case (ph_q)
      PH_HIGH: begin
        if (!hs_req) begin
          ph_d     = PH_GAP;
          gap_d    = '0;
          hs_rec_d = 1'b1;
        end
      end
      PH_LOW: begin
        if (!ls_req) begin
          ph_d  = PH_GAP;
          gap_d = '0;
        end
      end
      default: begin
        if (!gap_done) gap_d = gap_q + GW'(1);
        if (gap_done && hs_req) begin
          ph_d = PH_HIGH;
        end else if (ls_req && (gap_done || (force_low && !hs_rec_q))) begin
          ph_d     = PH_LOW;
          hs_rec_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_GAP;
      gap_q    <= '0;
      hs_rec_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      gap_q    <= gap_d;
      hs_rec_q <= hs_rec_d;
    end
  end

  assign hs_on = (ph_q == PH_HIGH);
  assign ls_on = (ph_q == PH_LOW);

  AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(!ls_on)); // R2
  AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(!hs_on)); // R2
endmodule

// File: rtl/bgs_drive_shaper.sv
module bgs_drive_shaper #(
  parameter int WEAK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_on,
  output logic hs_weak,
  output logic sw_tick
);
  logic hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= hs_on;
  end

  assign sw_tick = hs_on && !hs_q;

  generate
    if (WEAK_CYC > 0) begin : g_weak
      localparam int WW = $clog2(WEAK_CYC + 1);
      localparam logic [WW-1:0] WLIM = WW'(WEAK_CYC);
      logic [WW-1:0] wk_q, wk_d;
      always_comb begin
        if (!hs_on)          wk_d = '0;
        else if (wk_q < WLIM) wk_d = wk_q + WW'(1);
        else                 wk_d = wk_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
      end
      assign hs_weak = hs_on && (wk_q < WLIM);

      AST_WEAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> hs_weak); // R5
    end else begin : g_strong
      assign hs_weak = 1'b0;
    end
  endgenerate

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_tick |=> !sw_tick); // R6
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int DEAD_CYC = 3,
  parameter int WEAK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_below,
  input  logic zc_det,
  input  logic ilim_over,
  input  logic ilim_under,
  input  logic drv_off,
  input  logic fault_low,
  output logic hs_on,
  output logic ls_on,
  output logic hs_weak,
  output logic sw_tick
);
  logic hs_allow, ls_block, want_high, hs_req, ls_req;

  bgs_ilim_gate u_ilim (
    .clk(clk), .rst_n(rst_n), .ilim_over(ilim_over),
    .ilim_under(ilim_under), .hs_allow(hs_allow)
  );

  assign want_high = fb_below && hs_allow;

  bgs_zc_latch u_zc (
    .clk(clk), .rst_n(rst_n), .zc_det(zc_det),
    .want_high(want_high), .ls_block(ls_block)
  );

  assign hs_req = !drv_off && !fault_low && want_high;
  assign ls_req = !drv_off && (fault_low || (!want_high && !ls_block));

  bgs_phase_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .force_low(fault_low), .hs_on(hs_on), .ls_on(ls_on)
  );

  bgs_drive_shaper #(.WEAK_CYC(WEAK_CYC)) u_shape (
    .clk(clk), .rst_n(rst_n), .hs_on(hs_on),
    .hs_weak(hs_weak), .sw_tick(sw_tick)
  );

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on)); // R1
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    drv_off |=> (!hs_on && !ls_on)); // R7
  AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_over |=> !hs_on); // R4
  AST_FAULT_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_low |=> !hs_on); // R8
  AST_ZC_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_det && !fb_below && !fault_low) |=> !ls_on); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!hs_on && !ls_on && !hs_weak && !sw_tick)); // R10
endmodule

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;
  localparam int DEAD = 3;
  localparam int WEAK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_below = 1'b0, zc_det = 1'b0, ilim_over = 1'b0, ilim_under = 1'b0;
  logic drv_off = 1'b0, fault_low = 1'b0;
  logic hs_on, ls_on, hs_weak, sw_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  buck_gate_seq #(.DEAD_CYC(DEAD), .WEAK_CYC(WEAK)) u_dut (
    .clk(clk), .rst_n(rst_n), .fb_below(fb_below), .zc_det(zc_det),
    .ilim_over(ilim_over), .ilim_under(ilim_under), .drv_off(drv_off),
    .fault_low(fault_low), .hs_on(hs_on), .ls_on(ls_on),
    .hs_weak(hs_weak), .sw_tick(sw_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  // count cycles until the chosen output (0 = hs_on, 1 = ls_on) goes high
  task automatic wait_on(input bit which_ls, input int lim, output int n);
    n = 0;
    do begin
      cyc();
      n++;
    end while (((which_ls ? ls_on : hs_on) == 1'b0) && n < lim);
  endtask

  // per-cycle port monitor with its own model of the limit and zero-cross state
  bit blk_b = 0, zc_b = 0, prev_hs = 0;
  int off_hs = 0, off_ls = 0, run_hs = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      bit want;
      want = fb_below && !ilim_over && !blk_b;
      chk(!(hs_on && ls_on), "R1 overlap", int'(hs_on & ls_on), 0);
      if (drv_off) chk(!hs_on && !ls_on, "R7 disable", int'(hs_on | ls_on), 0);
      if (ilim_over || blk_b) chk(!hs_on, "R4 limit", int'(hs_on), 0);
      if (!fb_below) chk(!hs_on, "R2 hs without request", int'(hs_on), 0);
      if (want && !fault_low) chk(!ls_on, "R2 ls while hs wanted", int'(ls_on), 0);
      if (!fault_low && !want && (zc_b || zc_det))
        chk(!ls_on, "R3 zero-cross", int'(ls_on), 0);
      if (fault_low) chk(!hs_on, "R8 fault hs", int'(hs_on), 0);
      if (hs_on && !prev_hs) chk(off_ls >= DEAD, "R2 gap before hs", off_ls, DEAD);
      if (hs_on) begin
        chk(hs_weak == (run_hs < WEAK), "R5 weak", int'(hs_weak), int'(run_hs < WEAK));
        chk(sw_tick == (run_hs == 0), "R6 tick", int'(sw_tick), int'(run_hs == 0));
      end else begin
        chk(!hs_weak && !sw_tick, "R5 R6 idle", int'(hs_weak | sw_tick), 0);
      end
      if (ls_on && off_ls > 0 && !fault_low)
        chk(off_hs >= DEAD, "R2 gap before ls", off_hs, DEAD);
      if (ilim_over) blk_b = 1; else if (ilim_under) blk_b = 0;
      if (want) zc_b = 0; else if (zc_det) zc_b = 1;
      off_ls = ls_on ? 0 : off_ls + 1;
      off_hs = hs_on ? 0 : off_hs + 1;
      run_hs = hs_on ? run_hs + 1 : 0;
      prev_hs = hs_on;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] lf;
    // R10 reset state
    repeat (3) cyc();
    chk(!hs_on && !ls_on && !hs_weak && !sw_tick, "R10 reset",
        int'({hs_on, ls_on, hs_weak, sw_tick}), 0);
    @(negedge clk);
    mon_en = 1'b1;
    #1 rst_n = 1'b1;
    // R2 first low-side turn-on after reset release
    wait_on(1'b1, 20, n);
    chk(n == DEAD, "R2 ls after reset", n, DEAD);
    repeat (2) cyc();
    // R2 switch to high side, R6 tick on first high cycle
    fb_below = 1'b1;
    cyc();
    chk(!ls_on, "R2 ls released", int'(ls_on), 0);
    n = 1;
    while (!hs_on && n < 20) begin cyc(); n++; end
    chk(n == DEAD + 1, "R2 hs latency", n, DEAD + 1);
    chk(sw_tick && hs_weak, "R6 tick at turn-on", int'(sw_tick), 1);
    repeat (4) cyc();
    // R4 current limit cut and hysteretic release
    ilim_over = 1'b1; cyc(); ilim_over = 1'b0;
    chk(!hs_on, "R4 cut", int'(hs_on), 0);
    for (int i = 0; i < 10; i++) cyc();
    chk(!hs_on, "R4 held until lower limit", int'(hs_on), 0);
    ilim_under = 1'b1; cyc(); ilim_under = 1'b0;
    wait_on(1'b0, 4 * DEAD + 4, n);
    chk(hs_on, "R4 release", int'(hs_on), 1);
    repeat (3) cyc();
    // R3 zero-crossing latch
    fb_below = 1'b0;
    wait_on(1'b1, 20, n);
    chk(n == DEAD + 1, "R2 ls latency", n, DEAD + 1);
    zc_det = 1'b1; cyc(); zc_det = 1'b0;
    chk(!ls_on, "R3 ls off on zero-cross", int'(ls_on), 0);
    for (int i = 0; i < 10; i++) cyc();
    chk(!ls_on, "R3 latch holds", int'(ls_on), 0);
    fb_below = 1'b1;
    wait_on(1'b0, 20, n);
    fb_below = 1'b0;
    wait_on(1'b1, 20, n);
    chk(n == DEAD + 1, "R3 latch cleared by hs", n, DEAD + 1);
    // R9 fault from low side skips the gap
    zc_det = 1'b1; cyc(); zc_det = 1'b0;
    fault_low = 1'b1; cyc();
    chk(ls_on, "R9 fault ls immediate", int'(ls_on), 1);
    fb_below = 1'b1;
    for (int i = 0; i < 6; i++) cyc();
    chk(ls_on && !hs_on, "R8 fault holds ls", int'(ls_on), 1);
    fault_low = 1'b0;
    wait_on(1'b0, 20, n);
    repeat (3) cyc();
    // R9 fault after high side keeps the gap
    fault_low = 1'b1;
    wait_on(1'b1, 20, n);
    chk(n == DEAD + 1, "R9 fault after hs", n, DEAD + 1);
    // R7 disable overrides fault
    drv_off = 1'b1; cyc();
    chk(!hs_on && !ls_on, "R7 off over fault", int'(ls_on), 0);
    for (int i = 0; i < 5; i++) cyc();
    chk(!hs_on && !ls_on, "R7 stays off", int'(ls_on), 0);
    drv_off = 1'b0; fault_low = 1'b0; fb_below = 1'b0;
    // random sweep checked by the monitor
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      cyc();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) fb_below = ~fb_below;
      zc_det     = (lf[7:4] == 4'd0);
      ilim_over  = (lf[11:8] == 4'hF) && lf[3];
      ilim_under = lf[9];
      drv_off    = (lf[15:11] == 5'd0);
      fault_low  = (lf[14:10] == 5'h1F) && lf[1];
    end
    cyc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule